// File: doc/BRIEF.md
# Processor Heartbeat Watchdog with Reset Pulse Generator

This block watches a heartbeat line that a processor toggles from software. If the line stops changing for longer than the allowed interval, the block drives an active-low reset pulse of fixed length. A supply-fault flag from an external voltage comparator forces the same reset. All intervals are counted in ticks of a single timebase clock.

After every reset the block allows the long interval, even when the short interval is selected. This gives the processor time to start up. The short interval takes effect only after the first heartbeat transition seen while reset is inactive. The watchdog can be disabled entirely. A status flag records whether the most recent reset came from a watchdog expiry or from a supply fault.

Top module: `wdt_reset_gen`

## Requirements
- R1: A rising edge and a falling edge of `hb_in` both restart the timeout count. The line passes through a two-flop synchronizer, so a transition applied in the cycle after high-output sample k of the run is counted at the clock edge that ends sample k+2. After that edge the next timeout is measured from zero.
- R2: With `sel_short`=1, after the first counted edge the run ends after `SHORT_TICKS` further cycles. A single edge after sample k therefore gives k+2+`SHORT_TICKS` high samples in total. With `sel_short`=0 the same run gives k+2+`LONG_TICKS` high samples.
- R3: After any reset ends, `rst_n` stays high for exactly `LONG_TICKS` cycles when no edge arrives, for either value of `sel_short`.
- R4: Heartbeat edges that occur while `rst_n` is low do not enable the short timeout.
- R5: While `hb_in` stays at a constant level and the watchdog is enabled, reset pulses repeat, each separated by a high phase of `LONG_TICKS` cycles.
- R6: Each reset pulse holds `rst_n` low for `NARROW_TICKS` cycles when `wide_rst`=0 and for `WIDE_TICKS` cycles when `wide_rst`=1.
- R7: While `sup_fault` is 1, `rst_n` is held low continuously. The pulse-width count starts only after the flag returns to 0. The watchdog does not count during this time.
- R8: With `wd_en`=0, `rst_n` never falls because of missing heartbeat edges.
- R9: `init`=1 at a clock edge drives `rst_n` low and `wd_trip` to 0 after that edge. A full reset pulse follows, and then the long timeout applies.
- R10: `wd_trip` is 1 during and after a reset caused by watchdog expiry. It is 0 from the first cycle of a reset caused by a supply fault.
- R11: Steady toggling of `hb_in` at intervals shorter than the short timeout keeps `rst_n` high indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| init | input | 1 | Synchronous power-on initialization, active high |
| hb_in | input | 1 | Asynchronous heartbeat line from the processor |
| sel_short | input | 1 | 1 selects the short timeout, 0 selects the long timeout |
| wd_en | input | 1 | 1 enables watchdog expiry |
| wide_rst | input | 1 | 1 selects the wide reset pulse, 0 selects the narrow pulse |
| sup_fault | input | 1 | Supply-fault flag, active high, synchronous to clk |
| rst_n | output | 1 | Reset output, active low |
| wd_trip | output | 1 | 1 when the last reset came from watchdog expiry |

## Verification
The bench builds the block with a short timeout of 16, a long timeout of 64, and pulse widths of 8 and 32 ticks. With these values every phase lasts only tens of cycles. This makes it practical to sweep all four combinations of timeout select and pulse-width select, and to measure each high and low phase exactly against arithmetic expectations. The small values also leave room for the grace-period, synchronizer-latency, supply-fault and disable cases inside a short run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_PULSE = 2'd1,
    ST_RUN   = 2'd2
  } wdt_state_e;

  // Timeout in force: the long value applies while the grace flag is set.
  function automatic int unsigned pick_limit(input logic short_sel, input logic grace,
                                             input int unsigned short_t,
                                             input int unsigned long_t);
    return (short_sel && !grace) ? short_t : long_t;
  endfunction

  function automatic int unsigned pick_width(input logic wide, input int unsigned narrow_w,
                                             input int unsigned wide_w);
    return wide ? wide_w : narrow_w;
  endfunction

endpackage

// File: rtl/wdt_hb_sync.sv
module wdt_hb_sync (
  input  logic clk,
  input  logic init,
  input  logic hb_in,
  output logic hb_edge
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (init) begin
      s1_q <= hb_in;
      s2_q <= hb_in;
      s3_q <= hb_in;
    end else begin
      s1_q <= hb_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign hb_edge = s2_q ^ s3_q;

  // R1: an edge pulse marks a change that entered the synchronizer earlier
  assert_edge_from_input_R1: assert property (@(posedge clk) disable iff (init)
    hb_edge |-> (s2_q != $past(s2_q)));
endmodule

// File: rtl/wdt_timeout.sv
module wdt_timeout #(
  parameter int unsigned SHORT_TICKS = 1024,
  parameter int unsigned LONG_TICKS  = 4096
) (
  input  logic clk,
  input  logic init,
  input  logic run,
  input  logic wd_en,
  input  logic sel_short,
  input  logic hb_edge,
  output logic expire
);
  import wdt_pkg::*;
  localparam int CW = $clog2(LONG_TICKS + 1);

  logic [CW-1:0] cnt_q;
  logic          grace_q;
  logic [CW-1:0] lim;

  assign lim    = CW'(pick_limit(sel_short, grace_q, SHORT_TICKS, LONG_TICKS));
  assign expire = run && wd_en && !hb_edge && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk) begin
    if (init || !run) begin
      cnt_q   <= '0;
      grace_q <= 1'b1;
    end else if (hb_edge) begin
      cnt_q   <= '0;
      grace_q <= 1'b0;
    end else if (expire) begin
      cnt_q   <= '0;
    end else if (wd_en) begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  // R3: count never passes the long limit
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (init)
    cnt_q < CW'(LONG_TICKS));
  // R4: grace stays armed while reset is active
  assert_grace_in_reset_R4: assert property (@(posedge clk) disable iff (init)
    !run |=> grace_q);
  // R8: disabled watchdog never expires
  assert_no_expire_disabled_R8: assert property (@(posedge clk) disable iff (init)
    !wd_en |-> !expire);
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned NARROW_TICKS = 512,
  parameter int unsigned WIDE_TICKS   = 2048
) (
  input  logic clk,
  input  logic init,
  input  logic sup_fault,
  input  logic wide_rst,
  input  logic expire,
  output logic run,
  output logic wd_trip
);
  import wdt_pkg::*;
  localparam int WW = $clog2(WIDE_TICKS + 1);

  wdt_state_e    st_q;
  logic [WW-1:0] wcnt_q;
  logic          trip_q;
  logic          width_done;

  assign width_done = (wcnt_q == WW'(pick_width(wide_rst, NARROW_TICKS, WIDE_TICKS)) - WW'(1));

  always_ff @(posedge clk) begin
    if (init) begin
      st_q   <= sup_fault ? ST_HOLD : ST_PULSE;
      wcnt_q <= '0;
      trip_q <= 1'b0;
    end else if (sup_fault) begin
      st_q   <= ST_HOLD;
      wcnt_q <= '0;
      trip_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_HOLD: begin
          st_q   <= ST_PULSE;
          wcnt_q <= '0;
        end
        ST_PULSE: begin
          if (width_done) begin
            st_q   <= ST_RUN;
            wcnt_q <= '0;
          end else begin
            wcnt_q <= wcnt_q + WW'(1);
          end
        end
        default: begin
          if (expire) begin
            st_q   <= ST_PULSE;
            wcnt_q <= '0;
            trip_q <= 1'b1;
          end
        end
      endcase
    end
  end

  assign run     = (st_q == ST_RUN);
  assign wd_trip = trip_q;

  // R6: width count stays within the wide limit
  assert_width_bound_R6: assert property (@(posedge clk) disable iff (init)
    wcnt_q < WW'(WIDE_TICKS));
  // R10: expiry marks the trip flag
  assert_trip_on_expire_R10: assert property (@(posedge clk) disable iff (init)
    (run && expire && !sup_fault) |=> wd_trip);
endmodule

// File: rtl/wdt_reset_gen.sv
module wdt_reset_gen #(
  parameter int unsigned SHORT_TICKS  = 1024,
  parameter int unsigned LONG_TICKS   = 4096,
  parameter int unsigned NARROW_TICKS = 512,
  parameter int unsigned WIDE_TICKS   = 2048
) (
  input  logic clk,
  input  logic init,
  input  logic hb_in,
  input  logic sel_short,
  input  logic wd_en,
  input  logic wide_rst,
  input  logic sup_fault,
  output logic rst_n,
  output logic wd_trip
);
  logic hb_edge;
  logic expire;
  logic run;

  wdt_hb_sync u_sync (
    .clk    (clk),
    .init   (init),
    .hb_in  (hb_in),
    .hb_edge(hb_edge)
  );

  wdt_timeout #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_tmo (
    .clk      (clk),
    .init     (init),
    .run      (run),
    .wd_en    (wd_en),
    .sel_short(sel_short),
    .hb_edge  (hb_edge),
    .expire   (expire)
  );

  wdt_pulse #(.NARROW_TICKS(NARROW_TICKS), .WIDE_TICKS(WIDE_TICKS)) u_pulse (
    .clk      (clk),
    .init     (init),
    .sup_fault(sup_fault),
    .wide_rst (wide_rst),
    .expire   (expire),
    .run      (run),
    .wd_trip  (wd_trip)
  );

  assign rst_n = run;

  // R7: a fault pulls reset low on the next cycle
  assert_fault_low_R7: assert property (@(posedge clk) disable iff (init)
    sup_fault |=> !rst_n);
  // R7: reset never releases directly out of a fault
  assert_no_release_in_fault_R7: assert property (@(posedge clk) disable iff (init)
    $rose(rst_n) |-> !$past(sup_fault));
  // R10: a fault clears the trip flag
  assert_fault_clears_trip_R10: assert property (@(posedge clk) disable iff (init)
    sup_fault |=> !wd_trip);
  // R8: with the watchdog off, reset only falls on a fault or init
  assert_disabled_stays_high_R8: assert property (@(posedge clk) disable iff (init)
    (rst_n && !wd_en && !sup_fault) |=> rst_n);
endmodule

// File: tb/wdt_reset_gen_test.sv
module wdt_reset_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_T  = 16;
  localparam int LONG_T   = 64;
  localparam int NARROW_T = 8;
  localparam int WIDE_T   = 32;
  localparam int CAP      = 1000;

  logic clk = 1'b0;
  logic init = 1'b1;
  logic hb_in = 1'b0;
  logic sel_short = 1'b0;
  logic wd_en = 1'b1;
  logic wide_rst = 1'b0;
  logic sup_fault = 1'b0;
  logic rst_n, wd_trip;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_reset_gen #(.SHORT_TICKS(SHORT_T), .LONG_TICKS(LONG_T),
                  .NARROW_TICKS(NARROW_T), .WIDE_TICKS(WIDE_T)) uut (
    .clk(clk), .init(init), .hb_in(hb_in), .sel_short(sel_short), .wd_en(wd_en),
    .wide_rst(wide_rst), .sup_fault(sup_fault), .rst_n(rst_n), .wd_trip(wd_trip)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts consecutive negedge samples at level lvl, starting with the current one.
  task automatic measure(input logic lvl, input int tog_at, output int n);
    n = 0;
    while (rst_n == lvl && n < CAP) begin
      n++;
      if (n == tog_at) hb_in = ~hb_in;
      @(negedge clk);
    end
  endtask

  task automatic do_init();
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 rst_n in init", int'(rst_n), 0);
    check("R9 wd_trip in init", int'(wd_trip), 0);

    for (int cfg = 0; cfg < 4; cfg++) begin
      int w;
      sel_short = cfg[0];
      wide_rst  = cfg[1];
      w = cfg[1] ? WIDE_T : NARROW_T;
      do_init();
      measure(1'b0, 0, n);
      check("R6 R9 pulse after init", n, w);
      measure(1'b1, 3, n);   // R1 R2 single edge after sample 3
      check("R2 high with one edge", n, cfg[0] ? 5 + SHORT_T : 5 + LONG_T);
      check("R10 trip after expiry", int'(wd_trip), 1);
      measure(1'b0, 0, n);
      check("R6 pulse after expiry", n, w);
      measure(1'b1, 0, n);
      check("R3 R5 grace with steady line", n, LONG_T);
      measure(1'b0, 0, n);
      check("R5 repeated pulse", n, w);
      measure(1'b1, 0, n);
      check("R5 repeated long phase", n, LONG_T);
    end

    // R4: edges during reset do not unlock the short timeout
    sel_short = 1'b1;
    wide_rst = 1'b0;
    do_init();
    hb_in = ~hb_in;
    measure(1'b0, 0, n);
    check("R4 pulse", n, NARROW_T);
    measure(1'b1, 0, n);
    check("R4 long after edge in reset", n, LONG_T);

    // R1 with falling and rising edges, R11 keep-alive
    do_init();
    measure(1'b0, 0, n);
    begin
      int lows = 0;
      for (int i = 0; i < 300; i++) begin
        if (i % 5 == 0) hb_in = ~hb_in;
        if (!rst_n) lows++;
        @(negedge clk);
      end
      check("R11 R1 toggling keeps reset high", lows, 0);
    end

    // R8 watchdog disabled
    do_init();
    measure(1'b0, 0, n);
    wd_en = 1'b0;
    begin
      int lows = 0;
      for (int i = 0; i < 3 * LONG_T; i++) begin
        if (!rst_n) lows++;
        @(negedge clk);
      end
      check("R8 disabled no reset", lows, 0);
    end
    wd_en = 1'b1;

    // R7 R10 supply fault
    do_init();
    measure(1'b0, 0, n);
    measure(1'b1, 0, n);   // expiry sets trip
    check("R10 trip set before fault", int'(wd_trip), 1);
    measure(1'b0, 0, n);
    for (int i = 0; i < 5; i++) @(negedge clk);
    sup_fault = 1'b1;
    @(negedge clk);
    check("R7 fault pulls low", int'(rst_n), 0);
    check("R10 fault clears trip", int'(wd_trip), 0);
    for (int i = 0; i < 40; i++) @(negedge clk);
    check("R7 held low in fault", int'(rst_n), 0);
    sup_fault = 1'b0;
    @(negedge clk);
    measure(1'b0, 0, n);
    check("R7 width after fault release", n, NARROW_T);
    measure(1'b1, 0, n);
    check("R7 R3 long after fault", n, LONG_T);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule